// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Master

This block is a two-wire bus master that reads a run of consecutive bytes from a serial EEPROM, always starting at word address zero. It drives the clock and data lines as open-drain signals. A drive output at 1 pulls its line low, and a drive output at 0 releases it. The block samples the data line through a synchronizer. Every bus phase lasts a programmable number of system clocks. The default is 1250 clocks, which gives roughly 5 microseconds at 250 MHz.

The host sets a byte count and pulses start. The block then performs these steps in order:

1. It frees a stuck data line by pulsing the clock.
2. It issues a START.
3. It sends the write address and a word address of zero.
4. It issues a repeated START and sends the read address.
5. It shifts in the requested bytes and acknowledges each one except the last.
6. It closes with a STOP and retries the STOP if the data line stays low.

Each byte appears on the data output together with a one-cycle valid strobe. The transfer ends with a one-cycle done pulse or a one-cycle error pulse.

Top module: `eep_seq_reader`

## Requirements
- R1: In reset and whenever idle, both drive outputs are 0 (lines released) and busy, valid, done and error are all low.
- R2: A start with a count of zero gives a done pulse in the cycle after start, keeps busy low and produces no clock edge on the bus.
- R3: A transfer sends 0xA0, then 0x00, then a repeated START, then 0xA1. A good transfer shows exactly two STARTs and one STOP, and its data comes from word address zero onward.
- R4: A drive output at 1 pulls its line low and a 0 releases it. The sensed data input is not inverted, so an idle bus reads high.
- R5: Bytes are received MSB first. Each byte is presented on the data output with a single-cycle valid, and there is exactly one valid per requested byte.
- R6: The master acknowledges every received byte except the last by holding data low for one clock. It leaves data released (NACK) after the last byte.
- R7: If data is sampled high in the acknowledge slot after any of the three address bytes, the transfer ends with an error pulse, no done and no valid.
- R8: If data reads low just before START, up to 10 clock pulses are issued with data released, stopping as soon as data reads high. If data is still low after 10 pulses, an error pulse ends the transfer.
- R9: The STOP (a clock pulse with data low, then data released while the clock is high) is retried up to 10 times until data reads high. If data never reads high, an error pulse is given, and the bytes already delivered stand.
- R10: Done and error are single-cycle pulses that never coincide. Busy is high from the cycle after start and falls in the cycle of the result pulse.
- R11: Each level of the clock line is held for at least the half-period parameter in system clocks.
- R12: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| count_i | input | 8 | Number of bytes to read |
| sda_i | input | 1 | Sensed level of the data line |
| scl_drv_o | output | 1 | Clock line drive, 1 pulls low |
| sda_drv_o | output | 1 | Data line drive, 1 pulls low |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | One-cycle pulse on success |
| error_o | output | 1 | One-cycle pulse on failure |
| busy_o | output | 1 | High during a transfer |

## Verification
The block is run against a behavioural EEPROM on a wired-AND bus. The bench tries random byte counts and random memory contents, which tell bit order, the word-address reset of the pointer and the ACK/NACK placement apart from byte-count errors. Directed runs inject a NACK after each of the three address bytes separately, which shows whether each acknowledge slot is checked. A data line held low for 11 versus 12 clock falls separates a recovery that succeeds at the limit from one that fails. Further directed runs cover a STOP that never completes, a zero count, a 255-byte read and a start pulse during a transfer.

// File: rtl/eep_rd_pkg.sv
package eep_rd_pkg;
  typedef enum logic [3:0] {
    RD_IDLE,
    RD_PRE_LO,
    RD_PRE_HI,
    RD_UNSTICK,
    RD_START,
    RD_TX,
    RD_RX,
    RD_STOP_PULSE,
    RD_STOP_REL
  } rd_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
  parameter int unsigned HALF_CYC = 1250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = LAST;
    else              cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eep_in_sync.sv
module eep_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b1;
          else        chain_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/eep_shifter.sv
module eep_shifter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)       q_d = load_val;
    else if (shift) q_d = {q[W-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/eep_seq_reader.sv
module eep_seq_reader
  import eep_rd_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 1250,
  parameter int unsigned RETRY_MAX   = 10,
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] count_i,
  input  logic              sda_i,
  output logic              scl_drv_o,
  output logic              sda_drv_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              error_o,
  output logic              busy_o
);
  localparam int unsigned TRY_W = $clog2(RETRY_MAX + 1);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(RETRY_MAX - 1);
  localparam logic [BYTE_W-1:0] WR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] RD_BYTE = {DEV_ADDR, 1'b1};

  rd_state_e         st_q, st_d;
  logic [1:0]        ph_q, ph_d;
  logic [3:0]        bc_q, bc_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic [1:0]        hdr_q, hdr_d;
  logic [BYTE_W-1:0] rem_q, rem_d;
  logic              scl_q, scl_d, sda_q, sda_d;
  logic              valid_q, valid_d, done_q, done_d, err_q, err_d;
  logic              tick, sda_s, sh_load, sh_shift;
  logic [BYTE_W-1:0] sh_val, sh_q;
  logic              pulse_drv;

  eep_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st_q != RD_IDLE), .tick(tick)
  );

  eep_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_s)
  );

  eep_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(sh_val),
    .shift(sh_shift), .sin(sda_s), .q(sh_q)
  );

  // next-state logic
  always_comb begin
    st_d = st_q; ph_d = ph_q; bc_d = bc_q; try_d = try_q;
    hdr_d = hdr_q; rem_d = rem_q;
    valid_d = 1'b0; done_d = 1'b0; err_d = 1'b0;
    sh_load = 1'b0; sh_shift = 1'b0; sh_val = WR_BYTE;
    unique case (st_q)
      RD_IDLE: if (start_i) begin
        if (count_i == '0) done_d = 1'b1;
        else begin
          st_d = RD_PRE_LO; rem_d = count_i; hdr_d = 2'd0;
        end
      end
      RD_PRE_LO: if (tick) st_d = RD_PRE_HI;
      RD_PRE_HI: if (tick) begin
        if (sda_s) st_d = RD_START;
        else begin st_d = RD_UNSTICK; ph_d = 2'd0; try_d = '0; end
      end
      RD_UNSTICK: if (tick) begin
        if (ph_q != 2'd2) ph_d = ph_q + 2'd1;
        else if (sda_s) st_d = RD_START;
        else if (try_q == TRY_LAST) begin st_d = RD_IDLE; err_d = 1'b1; end
        else begin try_d = try_q + 1'b1; ph_d = 2'd0; end
      end
      RD_START: if (tick) begin
        st_d = RD_TX; ph_d = 2'd0; bc_d = 4'd0; sh_load = 1'b1;
        sh_val = (hdr_q == 2'd2) ? RD_BYTE : WR_BYTE;
      end
      RD_TX: if (tick) begin
        if (ph_q != 2'd2) ph_d = ph_q + 2'd1;
        else begin
          ph_d = 2'd0;
          if (bc_q != 4'd8) begin bc_d = bc_q + 4'd1; sh_shift = 1'b1; end
          else if (sda_s) begin st_d = RD_IDLE; err_d = 1'b1; end
          else begin
            bc_d = 4'd0;
            unique case (hdr_q)
              2'd0:    begin hdr_d = 2'd1; sh_load = 1'b1; sh_val = '0; end
              2'd1:    begin hdr_d = 2'd2; st_d = RD_PRE_LO; end
              default: st_d = RD_RX;
            endcase
          end
        end
      end
      RD_RX: if (tick) begin
        if (ph_q != 2'd2) ph_d = ph_q + 2'd1;
        else begin
          ph_d = 2'd0;
          if (bc_q != 4'd8) begin
            bc_d = bc_q + 4'd1; sh_shift = 1'b1;
            valid_d = (bc_q == 4'd7);
          end else begin
            bc_d = 4'd0; rem_d = rem_q - 1'b1;
            if (rem_q == 8'd1) begin st_d = RD_STOP_PULSE; try_d = '0; end
          end
        end
      end
      RD_STOP_PULSE: if (tick) begin
        if (ph_q != 2'd2) ph_d = ph_q + 2'd1;
        else st_d = RD_STOP_REL;
      end
      RD_STOP_REL: if (tick) begin
        if (sda_s) begin st_d = RD_IDLE; done_d = 1'b1; end
        else if (try_q == TRY_LAST) begin st_d = RD_IDLE; err_d = 1'b1; end
        else begin try_d = try_q + 1'b1; st_d = RD_STOP_PULSE; ph_d = 2'd0; end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  // pin drive for the state being entered (1 pulls the line low)
  always_comb begin
    unique case (st_d)
      RD_TX:   pulse_drv = (bc_d != 4'd8) ? ~sh_q[BYTE_W-1] : 1'b0;
      RD_RX:   pulse_drv = (bc_d == 4'd8) && (rem_q != 8'd1);
      default: pulse_drv = 1'b1;
    endcase
    scl_d = 1'b0; sda_d = 1'b0;
    unique case (st_d)
      RD_PRE_LO:  scl_d = 1'b1;
      RD_UNSTICK: scl_d = (ph_d != 2'd2);
      RD_START:   sda_d = 1'b1;
      RD_TX, RD_RX, RD_STOP_PULSE: begin
        scl_d = (ph_d != 2'd2);
        sda_d = (ph_d == 2'd0) ? sda_q : pulse_drv;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RD_IDLE; ph_q <= '0; bc_q <= '0; try_q <= '0;
      hdr_q <= '0; rem_q <= '0; scl_q <= 1'b0; sda_q <= 1'b0;
      valid_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bc_q <= bc_d; try_q <= try_d;
      hdr_q <= hdr_d; rem_q <= rem_d; scl_q <= scl_d; sda_q <= sda_d;
      valid_q <= valid_d; done_q <= done_d; err_q <= err_d;
    end
  end

  assign scl_drv_o = scl_q;
  assign sda_drv_o = sda_q;
  assign data_o    = sh_q;
  assign valid_o   = valid_q;
  assign done_o    = done_q;
  assign error_o   = err_q;
  assign busy_o    = (st_q != RD_IDLE);
endmodule

// File: rtl/eep_seq_reader_chk.sv
module eep_seq_reader_chk #(
  parameter int unsigned HALF_CYC = 1250
) (
  input logic clk,
  input logic rst_n,
  input logic scl_drv_o,
  input logic sda_drv_o,
  input logic valid_o,
  input logic done_o,
  input logic error_o,
  input logic busy_o
);
  localparam int unsigned RW = $clog2(HALF_CYC + 2);
  localparam logic [RW-1:0] SAT = RW'(HALF_CYC);

  logic          scl_prev_q, busy_prev_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b0; busy_prev_q <= 1'b0; run_q <= SAT;
    end else begin
      scl_prev_q  <= scl_drv_o;
      busy_prev_q <= busy_o;
      if (scl_drv_o != scl_prev_q) run_q <= RW'(1);
      else if (run_q < SAT)        run_q <= run_q + 1'b1;
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_drv_o && !sda_drv_o));

  // R10
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  error_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);

  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_prev_q && !busy_o) |-> (done_o || error_o));

  // R5
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> busy_o);

  // R11
  scl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_drv_o != scl_prev_q) |-> (run_q >= SAT));
endmodule

bind eep_seq_reader eep_seq_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_drv_o(scl_drv_o), .sda_drv_o(sda_drv_o),
  .valid_o(valid_o), .done_o(done_o), .error_o(error_o), .busy_o(busy_o)
);

// File: tb/eep_seq_reader_tb.sv
`timescale 1ns/1ps
module eep_seq_reader_tb_top;
  localparam int unsigned HALF = 8;

  logic       clk, rst_n, start_i;
  logic [7:0] count_i, data_o;
  logic       scl_drv_o, sda_drv_o, valid_o, done_o, error_o, busy_o;
  logic       sl_pull, force_low;
  logic       scl_w, sda_w;

  int tests, fails;
  bit finished;

  assign scl_w = ~scl_drv_o;
  assign sda_w = ~(sda_drv_o | sl_pull | force_low);

  eep_seq_reader #(.HALF_CYC(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .sda_i(sda_w), .scl_drv_o(scl_drv_o), .sda_drv_o(sda_drv_o),
    .data_o(data_o), .valid_o(valid_o), .done_o(done_o),
    .error_o(error_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural EEPROM
  int mode, sbc, hb, stuck_n, nack_sel, starts, stops, macks, mnacks, scl_falls;
  logic in_ack, stop_arm, stop_stuck;
  logic [7:0] ssh, sout, ptr, key;
  logic [7:0] hlog [4];

  function automatic logic [7:0] memv(input logic [7:0] a, input logic [7:0] k);
    return (a * 8'd29 + k) ^ 8'h5A;
  endfunction

  always @(negedge sda_w) if (scl_w === 1'b1 && !force_low) begin
    starts++; mode = 1; sbc = 0; in_ack = 1'b0; sl_pull = 1'b0;
  end

  always @(posedge sda_w) if (scl_w === 1'b1 && !force_low) begin
    stops++; mode = 0; in_ack = 1'b0; sl_pull = 1'b0;
  end

  always @(posedge scl_w) if (!force_low) begin
    if ((mode == 1 || mode == 2) && !in_ack && sbc < 8) begin
      ssh = {ssh[6:0], sda_w}; sbc++;
    end else if (mode == 3) begin
      if (sbc == 8) begin
        if (sda_w) begin mnacks++; mode = 0; stop_arm = 1'b1; end
        else macks++;
      end
      sbc++;
    end
  end

  always @(negedge scl_w) begin
    scl_falls++;
    if (force_low) begin
      if (stuck_n > 0) begin
        stuck_n--;
        if (stuck_n == 0) force_low = 1'b0;
      end
    end else if (stop_arm && stop_stuck) begin
      force_low = 1'b1; stop_arm = 1'b0;
    end else if (mode == 1 || mode == 2) begin
      if (in_ack) begin
        in_ack = 1'b0; sl_pull = 1'b0; sbc = 0;
        if (hb < 4) hlog[hb] = ssh;
        hb++;
        if (mode == 1) begin
          if (ssh == 8'hA1) begin
            mode = 3; sout = memv(ptr, key); ptr++; sl_pull = ~sout[7];
          end else mode = 2;
        end else begin
          ptr = ssh; mode = 0;
        end
      end else if (sbc == 8) begin
        in_ack = 1'b1; sl_pull = (hb + 1 != nack_sel);
      end
    end else if (mode == 3) begin
      if (sbc == 9) begin
        sout = memv(ptr, key); ptr++; sbc = 0; sl_pull = ~sout[7];
      end else if (sbc < 8) sl_pull = ~sout[7 - sbc];
      else sl_pull = 1'b0;
    end
  end

  // output monitor
  int nvalid, mism, done_n, err_n;
  always @(negedge clk) if (rst_n) begin
    if (valid_o) begin
      if (data_o !== memv(8'(nvalid), key)) mism++;
      nvalid++;
    end
    if (done_o)  done_n++;
    if (error_o) err_n++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic xfer(input int cnt, input logic [7:0] k, input int nsel,
                      input int stk, input bit stp, input bit poke,
                      input bit exp_err, input int exp_valid, input string rq);
    int guard;
    mode = 0; sbc = 0; in_ack = 1'b0; sl_pull = 1'b0; hb = 0;
    for (int i = 0; i < 4; i++) hlog[i] = 8'h00;
    stop_arm = 1'b0; key = k; nack_sel = nsel; stop_stuck = stp; ptr = 8'h77;
    if (stk > 0) begin stuck_n = stk; force_low = 1'b1; end
    @(negedge clk);
    starts = 0; stops = 0; macks = 0; mnacks = 0;
    nvalid = 0; mism = 0; done_n = 0; err_n = 0;
    start_i = 1'b1; count_i = 8'(cnt);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R10", "busy after start", int'(busy_o), 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      start_i = 1'b1; count_i = 8'd0;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(done_n == 0 && busy_o === 1'b1, "R12", "start while busy", done_n, 0);
    end
    guard = 0;
    while (done_n + err_n == 0 && guard < 150000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    chk(busy_o === 1'b0, "R10", "busy after end", int'(busy_o), 0);
    chk(nvalid == exp_valid, exp_err ? rq : "R5", "valid count", nvalid, exp_valid);
    chk(mism == 0, "R5", "data mismatches", mism, 0);
    if (exp_err) begin
      chk(err_n == 1 && done_n == 0, rq, "error pulses", err_n, 1);
    end else begin
      chk(done_n == 1 && err_n == 0, "R10", "done pulses", done_n, 1);
      chk(hb == 3, "R3", "address bytes", hb, 3);
      chk(hlog[0] == 8'hA0, "R3", "write address", int'(hlog[0]), 'hA0);
      chk(hlog[1] == 8'h00, "R3", "word address", int'(hlog[1]), 0);
      chk(hlog[2] == 8'hA1, "R3", "read address", int'(hlog[2]), 'hA1);
      chk(starts == 2 && stops == 1, "R3", "start count", starts, 2);
      chk(macks == cnt - 1, "R6", "master acks", macks, cnt - 1);
      chk(mnacks == 1, "R6", "master nacks", mnacks, 1);
    end
    force_low = 1'b0; stuck_n = 0; stop_stuck = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int fall0;
    tests = 0; fails = 0; finished = 1'b0;
    sl_pull = 1'b0; force_low = 1'b0; stuck_n = 0; stop_stuck = 1'b0;
    stop_arm = 1'b0; key = 8'h00; scl_falls = 0; mode = 0;
    start_i = 1'b0; count_i = 8'd0; rst_n = 1'b0;
    void'($urandom(32'hC0FFEE));
    repeat (5) @(negedge clk);
    chk(scl_drv_o === 1'b0 && sda_drv_o === 1'b0, "R1", "drives in reset",
        int'({scl_drv_o, sda_drv_o}), 0);
    chk(busy_o === 1'b0 && valid_o === 1'b0 && done_o === 1'b0 && error_o === 1'b0,
        "R1", "status in reset", int'({busy_o, valid_o, done_o, error_o}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(scl_w === 1'b1 && sda_w === 1'b1, "R4", "idle lines high",
        int'({scl_w, sda_w}), 3);

    // R2 zero count
    fall0 = scl_falls; done_n = 0;
    start_i = 1'b1; count_i = 8'd0;
    @(negedge clk);
    start_i = 1'b0;
    chk(done_o === 1'b1, "R2", "done after zero count", int'(done_o), 1);
    chk(busy_o === 1'b0, "R2", "busy on zero count", int'(busy_o), 0);
    repeat (40) @(negedge clk);
    chk(scl_falls == fall0, "R2", "clock falls", scl_falls - fall0, 0);

    xfer(1, 8'h13, 0, 0, 1'b0, 1'b0, 1'b0, 1, "R5");
    xfer(255, 8'hC4, 0, 0, 1'b0, 1'b0, 1'b0, 255, "R5");
    xfer(4, 8'h21, 1, 0, 1'b0, 1'b0, 1'b1, 0, "R7");
    xfer(4, 8'h22, 2, 0, 1'b0, 1'b0, 1'b1, 0, "R7");
    xfer(4, 8'h23, 3, 0, 1'b0, 1'b0, 1'b1, 0, "R7");
    xfer(3, 8'h31, 0, 11, 1'b0, 1'b0, 1'b0, 3, "R8");
    xfer(3, 8'h32, 0, 12, 1'b0, 1'b0, 1'b1, 0, "R8");
    xfer(5, 8'h41, 0, 0, 1'b1, 1'b0, 1'b1, 5, "R9");
    xfer(6, 8'h51, 0, 0, 1'b0, 1'b1, 1'b0, 6, "R12");
    for (int i = 0; i < 6; i++) begin
      int c;
      c = 1 + int'($urandom % 16);
      xfer(c, 8'($urandom), 0, 0, 1'b0, 1'b0, 1'b0, c, "R5");
    end
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    summary();
  end
endmodule